// File: doc/BRIEF.md
# Staggered Fan Power-On Sequencer

This block switches on six fan outputs one after another once the supply-ready input has been seen high, so that the inrush currents of the fans do not coincide. Between two successive enables it waits a step interval of a base tick count multiplied by the fan divisor. The divisor is the power of two selected by a three-bit code. With the default timing parameters, a 24 MHz clock and divisor 2, the six steps add up to 71.5 ms.

Fans come on in the fixed order 6, 2, 3, 1, 4, 5. An enable stays on until reset, or until supply-ready is seen low. A drop of supply-ready clears all enables. The next rising edge of supply-ready starts the sequence again from the first fan. A completion flag rises together with the last enable.

Top module: `fan_power_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `fan_en` and `seq_done` is 0.
- R2: While `supply_ok` is low no enable is ever set, whatever `div_code` holds.
- R3: Each step sets exactly one new enable, in the fixed order fan 6, fan 2, fan 3, fan 1, fan 4, fan 5. Fan n is `fan_en[n-1]`, so the bit order is 5, 1, 2, 0, 3, 4.
- R4: Call the first clock edge that samples `supply_ok` high edge 0. The j-th enable (j = 1..6) is set at edge j·P, where P = TICK_CYCLES · BASE_TICKS · 2^`div_code`.
- R5: `div_code` selects divisor 2^code (0 gives ÷1 and 7 gives ÷128), and every code from 0 to 7 scales P as in R4.
- R6: Once set, an enable stays set for as long as `supply_ok` stays high.
- R7: At the first clock edge that samples `supply_ok` low, all enables and `seq_done` clear and the step timing is discarded.
- R8: A new rising edge of `supply_ok` restarts the sequence from fan 6, with the same timing as R4.
- R9: `seq_done` is 1 exactly when all six enables are set.
- R10: A change of `div_code` during a step applies to that step. If the ticks already counted in the step reach the new limit, the step completes at the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (resume or init reset) |
| supply_ok | input | 1 | Supply-ready indication, synchronous to `clk` |
| div_code | input | 3 | Fan divisor code, divisor = 2^code |
| fan_en | output | 6 | Fan enables, bit n-1 drives fan n |
| seq_done | output | 1 | All six fans enabled |

## Verification
The bench builds the block with TICK_CYCLES = 2 and BASE_TICKS = 3. A step then lasts 6 cycles at code 0 and 768 cycles at code 7. All eight divisor codes can therefore be walked through their full sequences, checking the enables cycle by cycle, in about ten thousand cycles. The short tick also lets the divisor change in R10 land at a known tick count, so the early completion of a step can be timed exactly.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;

   localparam int unsigned NUM_FANS = 6;
   localparam int unsigned STEP_W   = 3;
   localparam int unsigned CODE_W   = 3;
   localparam int unsigned MAX_SHIFT = (1 << CODE_W) - 1;

   // Step position at which each fan is switched on (R3): fan 6,2,3,1,4,5.
   function automatic int unsigned step_of_fan(input int unsigned fan_bit);
      case (fan_bit)
         5:       return 0;
         1:       return 1;
         2:       return 2;
         0:       return 3;
         3:       return 4;
         default: return 5;
      endcase
   endfunction

endpackage

// File: rtl/fan_seq_prescale.sv
module fan_seq_prescale #(
   parameter int unsigned TICK_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);
   localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("fan_seq_prescale: TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_direct
      // Every running cycle is a tick.
      assign tick = run;
   end else begin : g_counted
      logic [PRE_W-1:0] pre_cnt;
      logic             wrap;

      assign wrap = (pre_cnt == PRE_W'(TICK_CYCLES - 1));
      assign tick = run && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_cnt <= '0;
         end else if (clear || !run) begin
            pre_cnt <= '0;
         end else if (wrap) begin
            pre_cnt <= '0;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fan_seq_interval.sv
module fan_seq_interval
   import fan_seq_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 143
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              tick,
   input  logic [CODE_W-1:0] div_code,
   output logic              step
);
   localparam int unsigned MAX_LIMIT = BASE_TICKS << MAX_SHIFT;
   localparam int unsigned TCNT_W    = $clog2(MAX_LIMIT + 1) + 1;

   if (BASE_TICKS < 1) begin : g_bad_base
      $error("fan_seq_interval: BASE_TICKS must be at least 1");
   end

   logic [TCNT_W-1:0] tick_cnt;
   logic [TCNT_W-1:0] limit;
   logic [TCNT_W-1:0] next_cnt;

   // R5: divisor is 2^code, applied to the current step at once (R10).
   assign limit    = TCNT_W'(BASE_TICKS) << div_code;
   assign next_cnt = tick_cnt + 1'b1;
   assign step     = tick && (next_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (clear) begin
         tick_cnt <= '0;
      end else if (step) begin
         tick_cnt <= '0;
      end else if (tick) begin
         tick_cnt <= next_cnt;
      end
   end

endmodule

// File: rtl/fan_seq_order.sv
module fan_seq_order
   import fan_seq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                step,
   output logic [NUM_FANS-1:0] fan_en,
   output logic                done
);
   logic [STEP_W-1:0] step_idx;

   assign done = (step_idx == STEP_W'(NUM_FANS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_idx <= '0;
      end else if (clear) begin
         step_idx <= '0;
      end else if (step && !done) begin
         step_idx <= step_idx + 1'b1;
      end
   end

   // One sticky enable per fan, set at its own step position (R3, R6).
   for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
      localparam logic [STEP_W-1:0] MY_STEP = STEP_W'(step_of_fan(f));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fan_en[f] <= 1'b0;
         end else if (clear) begin
            fan_en[f] <= 1'b0;
         end else if (step && (step_idx == MY_STEP)) begin
            fan_en[f] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fan_power_seq.sv
module fan_power_seq
   import fan_seq_pkg::*;
#(
   parameter int unsigned TICK_CYCLES = 1000,
   parameter int unsigned BASE_TICKS  = 143
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic [CODE_W-1:0] div_code,
   output logic [5:0]        fan_en,
   output logic              seq_done
);
   if (NUM_FANS != 6) begin : g_bad_fans
      $error("fan_power_seq: order table is defined for six fans");
   end

   logic supply_q;
   logic clear;
   logic running;
   logic tick;
   logic step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supply_q <= 1'b0;
      end else begin
         supply_q <= supply_ok;
      end
   end

   // R7/R8: low supply or the first high sample restarts everything.
   assign clear   = !(supply_ok && supply_q);
   assign running = !clear && !seq_done;

   fan_seq_prescale #(
      .TICK_CYCLES (TICK_CYCLES)
   ) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .run   (running),
      .tick  (tick)
   );

   fan_seq_interval #(
      .BASE_TICKS (BASE_TICKS)
   ) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .tick     (tick),
      .div_code (div_code),
      .step     (step)
   );

   fan_seq_order u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .step   (step),
      .fan_en (fan_en),
      .done   (seq_done)
   );

endmodule

// File: rtl/fan_power_seq_chk.sv
module fan_power_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic [5:0] fan_en,
   input logic       seq_done
);
   // R1: first cycle after reset release shows a cleared state.
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (fan_en == 6'b0 && !seq_done));

   // R7: a low supply sample clears every output by the next edge.
   a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (fan_en == 6'b0 && !seq_done));

   // R6: enables never drop while supply stays high.
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok |=> ((fan_en & $past(fan_en)) == $past(fan_en)));

   // R3: at most one enable changes per cycle while supply is high.
   a_r3_one_per_step: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok |=> ($countones(fan_en ^ $past(fan_en)) <= 1));

   // R3: the first enable to come on is fan 6.
   a_r3_first_fan6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fan_en) == 6'b0 && fan_en != 6'b0) |-> fan_en == 6'b100000);

   // R9: completion flag tracks the full set of enables.
   a_r9_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done == (fan_en == 6'b111111));
endmodule

bind fan_power_seq fan_power_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .supply_ok (supply_ok),
   .fan_en    (fan_en),
   .seq_done  (seq_done)
);

// File: tb/fan_power_seq_tb.sv
module fan_power_seq_tb;
   localparam int unsigned TB_TICK = 2;
   localparam int unsigned TB_BASE = 3;
   localparam int unsigned NVEC    = 8;

   // Vector table: {divisor code, expected step period in cycles}.
   typedef struct packed {
      logic [2:0]  code;
      logic [15:0] period;
   } vec_t;
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 16'd6},   '{3'd1, 16'd12},  '{3'd2, 16'd24},  '{3'd3, 16'd48},
      '{3'd4, 16'd96},  '{3'd5, 16'd192}, '{3'd6, 16'd384}, '{3'd7, 16'd768}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic [2:0] div_code = 3'd1;
   logic [5:0] fan_en;
   logic       seq_done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   fan_power_seq #(
      .TICK_CYCLES (TB_TICK),
      .BASE_TICKS  (TB_BASE)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .div_code  (div_code),
      .fan_en    (fan_en),
      .seq_done  (seq_done)
   );

   // Expected enables after n steps: fans 6,2,3,1,4,5 -> bits 5,1,2,0,3,4.
   function automatic logic [6:0] expect_after(input int n);
      logic [5:0] m = 6'b0;
      int order [6] = '{5, 1, 2, 0, 3, 4};
      for (int k = 0; k < 6 && k < n; k++) m[order[k]] = 1'b1;
      return {(n >= 6), m};
   endfunction

   task automatic chk(input string req, input logic [6:0] exp);
      n_checks++;
      if ({seq_done, fan_en} !== exp) begin
         n_fails++;
         $display("FAIL %s: {done,fan_en} actual=%b expected=%b at %0t",
                  req, {seq_done, fan_en}, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Advance one edge and sample at the following falling edge.
   task automatic step_edge();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state.
      repeat (2) @(negedge clk);
      chk("R1 during reset", 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 7'b0);

      // R2: supply held low, no enables for many cycles with any code.
      div_code = 3'd0;
      for (int c = 0; c < 40; c++) begin
         step_edge();
         if (c % 10 == 9) chk("R2 supply low ignored", 7'b0);
      end

      // R3/R4/R5/R9: full sequence for every divisor code.
      for (int i = 0; i < NVEC; i++) begin
         do_reset();
         div_code = VECS[i].code;
         @(negedge clk);
         supply_ok = 1'b1;
         for (int c = 0; c <= 6 * int'(VECS[i].period) + 2; c++) begin
            step_edge();
            chk("R4 R5 R3 R9 timing/order", expect_after(c / int'(VECS[i].period)));
         end
      end

      // R6/R7/R8: drop supply mid-sequence, then restart.
      do_reset();
      div_code = 3'd0;
      @(negedge clk);
      supply_ok = 1'b1;
      for (int c = 0; c <= 15; c++) step_edge();
      chk("R6 two fans held", expect_after(2));
      supply_ok = 1'b0;
      step_edge();
      chk("R7 clear on low sample", 7'b0);
      for (int c = 0; c < 20; c++) step_edge();
      chk("R7 stays clear while low", 7'b0);
      supply_ok = 1'b1;
      for (int c = 0; c <= 5; c++) step_edge();
      chk("R8 restart no early fan", 7'b0);
      step_edge();
      chk("R8 restart from fan6", expect_after(1));

      // R10: divisor lowered mid-step completes step at next tick.
      do_reset();
      div_code = 3'd7;
      @(negedge clk);
      supply_ok = 1'b1;
      for (int c = 0; c <= 20; c++) step_edge();
      chk("R10 before change", 7'b0);
      div_code = 3'd0;
      step_edge();
      chk("R10 between ticks", 7'b0);
      step_edge();
      chk("R10 step at next tick", expect_after(1));
      for (int c = 0; c < 5; c++) step_edge();
      chk("R10 new period before", expect_after(1));
      step_edge();
      chk("R10 new period applied", expect_after(2));

      // R1: reset asserted mid-sequence clears outputs.
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset mid-sequence", 7'b0);
      @(negedge clk);
      rst_n = 1'b1;
      supply_ok = 1'b0;
      step_edge();
      chk("R1 after mid reset", 7'b0);

      finish_run();
   end
endmodule